// File: doc/BRIEF.md
# Dual Serial-Memory Port Multiplexer

This block sits between two octal-capable SPI memory controllers and two physical memory ports. Each controller-side bus carries a serial clock, an active-low select, up to eight data lines with per-line output enables, and eight return data lines. Single, dual, quad and octal widths all pass through unchanged. A 2-bit routing mode connects the controllers straight or crossed, or puts both on one shared port. A separate 2-bit select-routing field steers each controller's select to the first or second select line of whichever port it reaches.

In the two shared modes only one controller may own the port at a time. A controller raises a request and waits for its grant before it asserts its select. It keeps the grant until it drops the request. Simultaneous requests are resolved round-robin. After each transaction a programmable number of idle clock cycles must pass before the next grant. In the dedicated modes a grant simply follows the request one cycle later. A new routing mode is taken only while no grant is outstanding, so a transaction is never re-routed in flight.

Top module: `mem_port_xbar`

## Requirements
- R1: Mode 0 (straight): controller 0 drives port 0 and reads port 0's input data, and controller 1 does the same with port 1. Data lane slice i of a flat bus is bits [8i+7:8i].
- R2: Mode 2 (swapped): controller 0 drives and reads port 1, and controller 1 drives and reads port 0.
- R3: Mode 1 shares port 0. Only the granted controller is routed there. Port 1 keeps both select outputs high and all output enables low.
- R4: Mode 3 shares port 1. Only the granted controller is routed there. Port 0 keeps both select outputs high and all output enables low.
- R5: During reset and after it, the routing mode is 0 and both grants are low.
- R6: Select routing: bit c of the select-routing field picks the select line (0 = first, 1 = second) that carries controller c's select. Values 0..3 therefore mean: both on the first line; controller 0 on the second and controller 1 on the first; controller 0 on the first and controller 1 on the second; both on the second. Port p's select line k is bit 2p+k of the port select output, and an unused line stays high.
- R7: In a shared mode at most one grant is high, and a grant stays high while its request stays high.
- R8: In a shared mode, simultaneous requests go to the controller with priority. Controller 0 has priority after reset. After every shared transaction, priority passes to the other controller.
- R9: In a shared mode, when a grant falls on clock edge E, the next grant rises no earlier than edge E+G+1, where G is the gap setting in cycles. With a request already waiting it rises exactly then, so G = 0 gives back-to-back grants one cycle apart.
- R10: In a shared mode, a controller without a grant sees its input data held at zero.
- R11: A change of the routing-mode input takes effect on the next clock edge only while both grants are low. Otherwise it waits until they are.
- R12: In modes 0 and 2, each controller's grant equals its request delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgMode | input | 2 | Requested routing mode |
| cfgCsSel | input | 2 | Select-routing field, bit c for controller c |
| cfgGap | input | GAP_W | Minimum idle cycles between shared transactions |
| ctlReq | input | 2 | Per-controller transaction request |
| ctlGrant | output | 2 | Per-controller grant |
| ctlSclk | input | 2 | Controller serial clocks |
| ctlCsN | input | 2 | Controller active-low selects |
| ctlDout | input | 2*DATA_W | Controller output data, lane per controller |
| ctlDoutEn | input | 2*DATA_W | Controller output enables |
| ctlDin | output | 2*DATA_W | Input data returned to each controller |
| portSclk | output | 2 | Port serial clocks |
| portCsN | output | 4 | Port selects, bit 2p+k is line k of port p |
| portDout | output | 2*DATA_W | Port output data |
| portOe | output | 2*DATA_W | Port output enables |
| portDin | input | 2*DATA_W | Port input data |

## Verification
On every cycle the assertions check four things. In a shared mode at most one grant is high, and a held request keeps its grant. The mode never moves while a grant is high. Each shared grant after a release waits out the programmed gap. The unused port and the ungranted controller are also checked to stay quiet. The assertions cannot show where the data actually goes. The bench's scenarios show the lane routing under each mode and select value, the tie order after reset and after each hand-over, the exact rise cycle after a gap, and a deferred mode change.

// File: rtl/mem_port_xbar_pkg.sv
package mem_port_xbar_pkg;

  typedef enum logic [1:0] {
    MODE_STRAIGHT = 2'd0,
    MODE_SHARE_P0 = 2'd1,
    MODE_SWAP     = 2'd2,
    MODE_SHARE_P1 = 2'd3
  } xbarMode_e;

  // strobes from control to datapath
  typedef struct packed {
    xbarMode_e  mode;
    logic [1:0] grant;
  } xbarCtl_t;

  // bit 0 of the mode marks the shared variants, bit 1 names the shared port
  function automatic logic isShared(xbarMode_e m);
    return m[0];
  endfunction

  function automatic logic sharedPort(xbarMode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/mem_port_xbar_ctrl.sv
module mem_port_xbar_ctrl
  import mem_port_xbar_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cfgMode,
  input  logic [GAP_W-1:0] cfgGap,
  input  logic [1:0]       req,
  output xbarCtl_t         ctl
);

  typedef enum logic [1:0] {ARB_IDLE, ARB_BUSY, ARB_GAP} arbState_e;

  xbarMode_e        modeQ;
  logic [1:0]       grantQ;
  arbState_e        stateQ;
  logic             ownerQ;
  logic             prioQ;
  logic [GAP_W-1:0] cntQ;

  logic modeLoad;
  logic pickHi;

  assign modeLoad = (grantQ == 2'b00) && (cfgMode != modeQ);
  // controller 1 wins if alone, or on a tie when it holds priority
  assign pickHi   = req[1] & (~req[0] | prioQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= MODE_STRAIGHT;
      grantQ <= 2'b00;
      stateQ <= ARB_IDLE;
      ownerQ <= 1'b0;
      prioQ  <= 1'b0;
      cntQ   <= '0;
    end else if (modeLoad) begin
      modeQ  <= xbarMode_e'(cfgMode);
      stateQ <= ARB_IDLE;
    end else if (!isShared(modeQ)) begin
      grantQ <= req;
      stateQ <= ARB_IDLE;
    end else begin
      unique case (stateQ)
        ARB_IDLE: begin
          if (|req) begin
            grantQ <= pickHi ? 2'b10 : 2'b01;
            ownerQ <= pickHi;
            stateQ <= ARB_BUSY;
          end
        end
        ARB_BUSY: begin
          if (!req[ownerQ]) begin
            grantQ <= 2'b00;
            prioQ  <= ~ownerQ;
            if (cfgGap == '0) begin
              stateQ <= ARB_IDLE;
            end else begin
              cntQ   <= cfgGap;
              stateQ <= ARB_GAP;
            end
          end
        end
        ARB_GAP: begin
          if (cntQ <= 1) stateQ <= ARB_IDLE;
          else           cntQ   <= cntQ - 1'b1;
        end
        default: stateQ <= ARB_IDLE;
      endcase
    end
  end

  assign ctl.mode  = modeQ;
  assign ctl.grant = grantQ;

  // ---------------- checks ----------------
  logic [GAP_W:0] idleCnt;
  logic           seenFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt  <= '0;
      seenFall <= 1'b0;
    end else begin
      if (grantQ != 2'b00) begin
        idleCnt <= '0;
      end else if (idleCnt != '1) begin
        idleCnt <= idleCnt + 1'b1;
      end
      if (modeLoad) seenFall <= 1'b0;
      else if (grantQ != 2'b00 && isShared(modeQ)) seenFall <= 1'b1;
    end
  end

  a_r7_single_grant: assert property (@(posedge clk) disable iff (!rstN)
    isShared(modeQ) |-> $onehot0(grantQ));

  a_r7_grant_held: assert property (@(posedge clk) disable iff (!rstN)
    (isShared(modeQ) && grantQ[0] && req[0]) |=> grantQ[0]);

  a_r11_mode_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (grantQ != 2'b00) |=> (modeQ == $past(modeQ)));

  a_r9_gap_kept: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(|grantQ) && isShared(modeQ) && $past(seenFall))
      |-> ($past(idleCnt) >= {1'b0, $past(cfgGap)}));

  a_r12_follow_req: assert property (@(posedge clk) disable iff (!rstN)
    (!isShared(modeQ) && !modeLoad && cfgMode == modeQ) |=> (grantQ == $past(req)));

endmodule

// File: rtl/mem_port_xbar_dp.sv
module mem_port_xbar_dp
  import mem_port_xbar_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  xbarCtl_t            ctl,
  input  logic [1:0]          cfgCsSel,
  input  logic [1:0]          ctlSclk,
  input  logic [1:0]          ctlCsN,
  input  logic [2*DATA_W-1:0] ctlDout,
  input  logic [2*DATA_W-1:0] ctlDoutEn,
  output logic [2*DATA_W-1:0] ctlDin,
  output logic [1:0]          portSclk,
  output logic [3:0]          portCsN,
  output logic [2*DATA_W-1:0] portDout,
  output logic [2*DATA_W-1:0] portOe,
  input  logic [2*DATA_W-1:0] portDin
);

  // port side: which controller (if any) drives each port
  for (genvar p = 0; p < 2; p++) begin : g_port
    logic srcValid;
    logic srcIdx;

    always_comb begin
      unique case (ctl.mode)
        MODE_STRAIGHT: begin srcValid = 1'b1; srcIdx = 1'(p);  end
        MODE_SWAP:     begin srcValid = 1'b1; srcIdx = ~1'(p); end
        default: begin
          srcValid = (sharedPort(ctl.mode) == 1'(p)) && (ctl.grant != 2'b00);
          srcIdx   = ctl.grant[1];
        end
      endcase
    end

    always_comb begin
      if (srcValid) begin
        portSclk[p]                = ctlSclk[srcIdx];
        portDout[p*DATA_W +: DATA_W] = ctlDout[srcIdx*DATA_W +: DATA_W];
        portOe[p*DATA_W +: DATA_W]   = ctlDoutEn[srcIdx*DATA_W +: DATA_W];
        portCsN[2*p]               = cfgCsSel[srcIdx] ? 1'b1 : ctlCsN[srcIdx];
        portCsN[2*p+1]             = cfgCsSel[srcIdx] ? ctlCsN[srcIdx] : 1'b1;
      end else begin
        portSclk[p]                = 1'b0;
        portDout[p*DATA_W +: DATA_W] = '0;
        portOe[p*DATA_W +: DATA_W]   = '0;
        portCsN[2*p]               = 1'b1;
        portCsN[2*p+1]             = 1'b1;
      end
    end

    a_r3_r4_idle_port: assert property (@(posedge clk) disable iff (!rstN)
      (isShared(ctl.mode) && sharedPort(ctl.mode) != 1'(p))
        |-> (portOe[p*DATA_W +: DATA_W] == '0 && portCsN[2*p +: 2] == 2'b11));
  end

  // controller side: which port each controller reads
  for (genvar c = 0; c < 2; c++) begin : g_ctl
    logic dstValid;
    logic dstIdx;

    always_comb begin
      unique case (ctl.mode)
        MODE_STRAIGHT: begin dstValid = 1'b1; dstIdx = 1'(c);  end
        MODE_SWAP:     begin dstValid = 1'b1; dstIdx = ~1'(c); end
        default: begin
          dstValid = ctl.grant[c];
          dstIdx   = sharedPort(ctl.mode);
        end
      endcase
    end

    assign ctlDin[c*DATA_W +: DATA_W] = dstValid ? portDin[dstIdx*DATA_W +: DATA_W] : '0;

    a_r10_quiet_loser: assert property (@(posedge clk) disable iff (!rstN)
      (isShared(ctl.mode) && !ctl.grant[c]) |-> (ctlDin[c*DATA_W +: DATA_W] == '0));
  end

endmodule

// File: rtl/mem_port_xbar.sv
module mem_port_xbar
  import mem_port_xbar_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GAP_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          cfgMode,
  input  logic [1:0]          cfgCsSel,
  input  logic [GAP_W-1:0]    cfgGap,
  input  logic [1:0]          ctlReq,
  output logic [1:0]          ctlGrant,
  input  logic [1:0]          ctlSclk,
  input  logic [1:0]          ctlCsN,
  input  logic [2*DATA_W-1:0] ctlDout,
  input  logic [2*DATA_W-1:0] ctlDoutEn,
  output logic [2*DATA_W-1:0] ctlDin,
  output logic [1:0]          portSclk,
  output logic [3:0]          portCsN,
  output logic [2*DATA_W-1:0] portDout,
  output logic [2*DATA_W-1:0] portOe,
  input  logic [2*DATA_W-1:0] portDin
);

  xbarCtl_t ctl;

  mem_port_xbar_ctrl #(.GAP_W(GAP_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgMode (cfgMode),
    .cfgGap  (cfgGap),
    .req     (ctlReq),
    .ctl     (ctl)
  );

  mem_port_xbar_dp #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .cfgCsSel  (cfgCsSel),
    .ctlSclk   (ctlSclk),
    .ctlCsN    (ctlCsN),
    .ctlDout   (ctlDout),
    .ctlDoutEn (ctlDoutEn),
    .ctlDin    (ctlDin),
    .portSclk  (portSclk),
    .portCsN   (portCsN),
    .portDout  (portDout),
    .portOe    (portOe),
    .portDin   (portDin)
  );

  assign ctlGrant = ctl.grant;

endmodule

// File: tb/mem_port_xbar_test.sv
module mem_port_xbar_test;

  localparam int DW = 8;
  localparam int GW = 8;
  localparam int CLK_NS = 20;

  logic          clk = 1'b0;
  logic          rstN;
  logic [1:0]    cfgMode, cfgCsSel;
  logic [GW-1:0] cfgGap;
  logic [1:0]    ctlReq, ctlGrant, ctlSclk, ctlCsN;
  logic [2*DW-1:0] ctlDout, ctlDoutEn, ctlDin;
  logic [1:0]    portSclk;
  logic [3:0]    portCsN;
  logic [2*DW-1:0] portDout, portOe, portDin;

  int errors = 0;
  int checks = 0;

  always #(CLK_NS/2) clk = ~clk;

  mem_port_xbar #(.DATA_W(DW), .GAP_W(GW)) uut (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgCsSel(cfgCsSel), .cfgGap(cfgGap),
    .ctlReq(ctlReq), .ctlGrant(ctlGrant), .ctlSclk(ctlSclk), .ctlCsN(ctlCsN),
    .ctlDout(ctlDout), .ctlDoutEn(ctlDoutEn), .ctlDin(ctlDin),
    .portSclk(portSclk), .portCsN(portCsN), .portDout(portDout), .portOe(portOe),
    .portDin(portDin)
  );

  // {mode, csSel, expCsN, expDout0, expDout1, expDin0, expDin1}
  localparam logic [39:0] VEC [8] = '{
    {2'd0, 2'd0, 4'b1010, 8'hA5, 8'h3C, 8'h11, 8'h22},
    {2'd0, 2'd1, 4'b1001, 8'hA5, 8'h3C, 8'h11, 8'h22},
    {2'd0, 2'd2, 4'b0110, 8'hA5, 8'h3C, 8'h11, 8'h22},
    {2'd0, 2'd3, 4'b0101, 8'hA5, 8'h3C, 8'h11, 8'h22},
    {2'd2, 2'd0, 4'b1010, 8'h3C, 8'hA5, 8'h22, 8'h11},
    {2'd2, 2'd1, 4'b0110, 8'h3C, 8'hA5, 8'h22, 8'h11},
    {2'd2, 2'd2, 4'b1001, 8'h3C, 8'hA5, 8'h22, 8'h11},
    {2'd2, 2'd3, 4'b0101, 8'h3C, 8'hA5, 8'h22, 8'h11}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int gapNs;
    int seenAt;
    rstN      = 1'b0;
    cfgMode   = 2'd0;
    cfgCsSel  = 2'd0;
    cfgGap    = '0;
    ctlReq    = 2'b00;
    ctlSclk   = 2'b01;
    ctlCsN    = 2'b00;
    ctlDout   = {8'h3C, 8'hA5};
    ctlDoutEn = 16'hFFFF;
    portDin   = {8'h22, 8'h11};

    tick(2);
    chk("R5 grant in reset", 32'(ctlGrant), 32'h0);
    chk("R5 straight in reset", 32'(portDout), 32'h3CA5);
    rstN = 1'b1;
    tick(1);
    chk("R5 grant after reset", 32'(ctlGrant), 32'h0);

    // routing table for the dedicated modes
    for (int i = 0; i < 8; i++) begin
      cfgMode  = VEC[i][39:38];
      cfgCsSel = VEC[i][37:36];
      tick(2);
      chk(VEC[i][39:38] == 2'd0 ? "R1/R6 csN" : "R2/R6 csN", 32'(portCsN), 32'(VEC[i][35:32]));
      chk(VEC[i][39:38] == 2'd0 ? "R1 dout" : "R2 dout", 32'(portDout),
          {16'h0, VEC[i][23:16], VEC[i][31:24]});
      chk(VEC[i][39:38] == 2'd0 ? "R1 din" : "R2 din", 32'(ctlDin),
          {16'h0, VEC[i][7:0], VEC[i][15:8]});
      chk(VEC[i][39:38] == 2'd0 ? "R1 sclk" : "R2 sclk", 32'(portSclk),
          VEC[i][39:38] == 2'd0 ? 32'h1 : 32'h2);
    end

    // R12: dedicated grant follows request by one cycle
    cfgMode = 2'd0; cfgCsSel = 2'd0;
    tick(2);
    ctlReq = 2'b01;
    tick(1);
    chk("R12 grant rises", 32'(ctlGrant), 32'h1);
    ctlReq = 2'b00;
    tick(1);
    chk("R12 grant falls", 32'(ctlGrant), 32'h0);

    // shared on port 0, gap converted from 100 ns at the bench clock
    gapNs   = 100;
    cfgGap  = GW'(gapNs / CLK_NS);
    cfgMode = 2'd1;
    tick(2);
    chk("R3 idle port oe", 32'(portOe[15:8]), 32'h0);
    chk("R3 idle port cs", 32'(portCsN[3:2]), 32'h3);
    ctlReq = 2'b11;
    tick(1);
    chk("R8 first tie to ctl0", 32'(ctlGrant), 32'h1);
    chk("R3 shared dout", 32'(portDout), 32'h00A5);
    chk("R3/R6 shared cs", 32'(portCsN), 32'hE);
    chk("R10 loser din", 32'(ctlDin[15:8]), 32'h0);
    chk("R3 winner din", 32'(ctlDin[7:0]), 32'h11);
    tick(3);
    chk("R7 grant held", 32'(ctlGrant), 32'h1);

    ctlReq = 2'b10;
    seenAt = 0;
    for (int k = 1; k <= 12; k++) begin
      tick(1);
      if (k == 1) chk("R7 release", 32'(ctlGrant), 32'h0);
      if (seenAt == 0 && ctlGrant[1]) seenAt = k;
    end
    chk("R9 gap of 5", 32'(seenAt), 32'd7);

    // R11: mode request while ctl1 holds grant is deferred
    cfgMode = 2'd3;
    tick(3);
    chk("R11 mode deferred", 32'(portDout), 32'h003C);
    chk("R11 grant kept", 32'(ctlGrant), 32'h2);
    ctlReq = 2'b00;
    tick(1);
    chk("R11 grant dropped", 32'(ctlGrant), 32'h0);
    tick(1);
    cfgGap = '0;
    ctlReq = 2'b11;
    tick(1);
    chk("R8 priority passed to ctl0", 32'(ctlGrant), 32'h1);
    chk("R4 shared dout", 32'(portDout), 32'hA500);
    chk("R4/R6 shared cs", 32'(portCsN), 32'hB);
    chk("R4 idle port oe", 32'(portOe[7:0]), 32'h0);
    chk("R10 loser din p1", 32'(ctlDin[15:8]), 32'h0);
    chk("R4 winner din", 32'(ctlDin[7:0]), 32'h22);

    // zero gap, tie after ctl0 transaction goes to ctl1
    ctlReq = 2'b10;
    tick(1);
    chk("R9 release", 32'(ctlGrant), 32'h0);
    ctlReq = 2'b11;
    tick(1);
    chk("R8/R9 back-to-back to ctl1", 32'(ctlGrant), 32'h2);
    chk("R4 ctl1 on port1", 32'(portDout), 32'h3C00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule